// File: doc/BRIEF.md
# Converter Standby Power-Cycling Sequencer

This block sits on the host side of a sampling converter and cuts its average supply current by parking the converter in low-current standby between conversion sequences. It issues an active-low conversion-start strobe, drives an active-low standby line and watches the converter's busy output. When busy drops at the end of a sequence, the standby line goes low. The sleep interval is measured in clock cycles. The standby line then goes high again early enough to cover the wake-up delay before the next start falls due, so starts stay on a programmable throughput period.

A sleep that reaches a programmable threshold, and the first power-up after reset, need a longer wake-up wait than a short nap. The block therefore keeps two wake-up counts and picks one from the measured sleep length. If the period is too short to fit busy time plus the short wake-up wait, the block never enters standby, runs the converter continuously and raises a status flag. All configuration inputs are expected to be static, and are changed only while reset is held. The block has no data path. Every pin is a plain control or status level, so no valid/ready back-pressure applies.

Top module: `cnv_sleep_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `standby_n` and `conv_start_n` are both high.
- R2: The first fall of `conv_start_n` after reset occurs exactly `cfg_wake_long`+1 clock edges after the last edge with `rst` high.
- R3: When standby is not skipped, `standby_n` falls on the first edge that samples `busy` low after sampling it high, one cycle after the pin drops.
- R4: Each fall of `conv_start_n` after a sleep occurs exactly L+1 cycles after `standby_n` rose, where L is the wake-up count chosen for that sleep.
- R5: The sleep length is the number of cycles `standby_n` stayed low. L is `cfg_wake_long` when this length is at least `cfg_long_thresh`, and `cfg_wake_short` otherwise. The length is evaluated at the edge on which the block decides to wake.
- R6: The block wakes on the first sleep edge at which waking with the current L lets the next start fall no earlier than `cfg_period` cycles after the previous one. The start-to-start spacing is therefore exactly `cfg_period` whenever that fits, and as small as possible otherwise.
- R7: Each strobe holds `conv_start_n` low for `cfg_pulse` cycles. A value of 0 gives a one-cycle strobe.
- R8: `conv_start_n` is never low while `standby_n` is low.
- R9: When `cfg_period` < `cfg_busy` + `cfg_wake_short` + 2, `skip_sleep` is high and `standby_n` stays high. In that mode the next start falls at max(`cfg_period`, e+1) cycles after the previous one, where e is the offset of the edge that saw busy fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Start-to-start period in cycles |
| cfg_busy | input | CNT_W | Expected busy time in cycles, used for the skip decision |
| cfg_wake_short | input | CNT_W | Wake-up count after a short sleep |
| cfg_wake_long | input | CNT_W | Wake-up count after a long sleep and after reset |
| cfg_long_thresh | input | CNT_W | Sleep length in cycles that counts as long |
| cfg_pulse | input | PW_W | Start strobe width in cycles |
| busy | input | 1 | Converter busy, high during a conversion sequence |
| conv_start_n | output | 1 | Active-low conversion-start strobe |
| standby_n | output | 1 | Active-low standby control |
| skip_sleep | output | 1 | High when the period is too short for standby |

## Verification
The assertions assume that busy rises only after a strobe begins and stays high longer than the strobe, so its fall is seen in the conversion-wait state. They also assume the configuration moves only under reset. The bench's converter model raises busy on the cycle it sees the strobe fall and holds it high for a drawn length of at least strobe width plus two. Each random configuration is applied with reset asserted, and the threshold, the period and the two wake-up counts are drawn so that short, long, late-wake and skip cases all occur.

// File: rtl/cnv_sleep_pkg.sv
package cnv_sleep_pkg;
  typedef enum logic [2:0] {
    ST_WAKE,
    ST_PULSE,
    ST_CONV,
    ST_IDLE,
    ST_SLEEP
  } seq_state_t;
endpackage

// File: rtl/cnv_period_timer.sv
module cnv_period_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                elapsed <= '0;
    else if (restart)       elapsed <= '0;
    else if (elapsed != SAT) elapsed <= elapsed + 1'b1;
  end

  // saturation keeps the spacing comparison valid (R6)
  assert_timer_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (elapsed == SAT && !restart) |=> elapsed == SAT);
endmodule

// File: rtl/cnv_load_counter.sv
module cnv_load_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)              value <= rst_val;
    else if (load)        value <= load_val;
    else if (value != '0) value <= value - 1'b1;
  end

  assign zero = (value == '0);

  // the count only steps down by one or reloads (R4, R7)
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && value != '0) |=> value == $past(value) - 1'b1);
endmodule

// File: rtl/cnv_sleep_meter.sv
module cnv_sleep_meter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] wake_short,
  input  logic [CNT_W-1:0] wake_long,
  output logic [CNT_W-1:0] lead,
  output logic             is_long
);
  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] slept;

  always_ff @(posedge clk) begin
    if (rst)                         slept <= '0;
    else if (clear)                  slept <= '0;
    else if (run && slept != SAT)    slept <= slept + 1'b1;
  end

  // sleep length if waking on this edge is slept+1 (R5)
  assign is_long = ({1'b0, slept} + EW'(1)) >= {1'b0, thresh};
  assign lead    = is_long ? wake_long : wake_short;

  assert_meter_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> slept == '0);
endmodule

// File: rtl/cnv_sleep_sequencer.sv
module cnv_sleep_sequencer
  import cnv_sleep_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PW_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_busy,
  input  logic [CNT_W-1:0] cfg_wake_short,
  input  logic [CNT_W-1:0] cfg_wake_long,
  input  logic [CNT_W-1:0] cfg_long_thresh,
  input  logic [PW_W-1:0]  cfg_pulse,
  input  logic             busy,
  output logic             conv_start_n,
  output logic             standby_n,
  output logic             skip_sleep
);
  localparam int SW = CNT_W + 2;

  seq_state_t       state;
  logic             busy_q;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] lead;
  logic             lead_long;
  logic [CNT_W-1:0] wake_val;
  logic             wake_zero;
  logic [PW_W-1:0]  pulse_val;
  logic             pulse_zero;
  logic [PW_W-1:0]  pulse_load_val;

  logic start_go, busy_fell, wake_due, per_due, skip_d, enter_sleep, wake_go;

  assign busy_fell   = busy_q && !busy;
  assign skip_d      = {2'b0, cfg_period} <
                       ({2'b0, cfg_busy} + {2'b0, cfg_wake_short} + SW'(2));
  assign per_due     = ({2'b0, elapsed} + SW'(1)) >= {2'b0, cfg_period};
  assign wake_due    = ({2'b0, elapsed} + {2'b0, lead} + SW'(2)) >= {2'b0, cfg_period};
  assign start_go    = (state == ST_WAKE && wake_zero) || (state == ST_IDLE && per_due);
  assign enter_sleep = (state == ST_CONV) && busy_fell && !skip_sleep;
  assign wake_go     = (state == ST_SLEEP) && wake_due;
  assign pulse_load_val = (cfg_pulse == '0) ? '0 : cfg_pulse - 1'b1;

  cnv_period_timer #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst(rst), .restart(start_go), .elapsed(elapsed)
  );

  cnv_sleep_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .clear(enter_sleep), .run(state == ST_SLEEP),
    .thresh(cfg_long_thresh), .wake_short(cfg_wake_short),
    .wake_long(cfg_wake_long), .lead(lead), .is_long(lead_long)
  );

  cnv_load_counter #(.W(CNT_W)) u_wake (
    .clk(clk), .rst(rst), .rst_val(cfg_wake_long), .load(wake_go),
    .load_val(lead), .value(wake_val), .zero(wake_zero)
  );

  cnv_load_counter #(.W(PW_W)) u_pulse (
    .clk(clk), .rst(rst), .rst_val('0), .load(start_go),
    .load_val(pulse_load_val), .value(pulse_val), .zero(pulse_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      skip_sleep <= 1'b0;
    end else begin
      busy_q     <= busy;
      skip_sleep <= skip_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAKE;
      conv_start_n <= 1'b1;
      standby_n    <= 1'b1;
    end else begin
      unique case (state)
        ST_WAKE: if (wake_zero) begin
          conv_start_n <= 1'b0;
          state        <= ST_PULSE;
        end
        ST_PULSE: if (pulse_zero) begin
          conv_start_n <= 1'b1;
          state        <= ST_CONV;
        end
        ST_CONV: if (busy_fell) begin
          if (skip_sleep) state <= ST_IDLE;
          else begin
            standby_n <= 1'b0;
            state     <= ST_SLEEP;
          end
        end
        ST_IDLE: if (per_due) begin
          conv_start_n <= 1'b0;
          state        <= ST_PULSE;
        end
        ST_SLEEP: if (wake_due) begin
          standby_n <= 1'b1;
          state     <= ST_WAKE;
        end
        default: state <= ST_WAKE;
      endcase
    end
  end

  // strobe only while awake
  assert_start_awake_R8: assert property (@(posedge clk) disable iff (rst)
    !conv_start_n |-> standby_n);

  // standby entered only on an observed busy fall
  assert_sleep_on_busy_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(standby_n) |-> ($past(busy_q) && !$past(busy)));

  // no standby while skipping
  assert_skip_awake_R9: assert property (@(posedge clk) disable iff (rst)
    skip_sleep |-> standby_n);

  // a start after a sleep needs the wake count to have run out
  assert_start_after_wake_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(conv_start_n) && $past(state) == ST_WAKE) |-> $past(wake_val) == '0);

  // a wake choosing the long count reports a long sleep
  assert_long_choice_R5: assert property (@(posedge clk) disable iff (rst)
    (wake_go && lead_long) |=> wake_val == cfg_wake_long);
endmodule

// File: tb/cnv_sleep_sequencer_bench.sv
module cnv_sleep_sequencer_bench;
  localparam int CW = 24;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_period = '0, cfg_busy = '0, cfg_wake_short = '0;
  logic [CW-1:0] cfg_wake_long = '0, cfg_long_thresh = '0;
  logic [PW-1:0] cfg_pulse = '0;
  logic busy = 1'b0;
  logic conv_start_n, standby_n, skip_sleep;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cnv_sleep_sequencer #(.CNT_W(CW), .PW_W(PW)) u_cnv_sleep_sequencer (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_busy(cfg_busy),
    .cfg_wake_short(cfg_wake_short), .cfg_wake_long(cfg_wake_long),
    .cfg_long_thresh(cfg_long_thresh), .cfg_pulse(cfg_pulse), .busy(busy),
    .conv_start_n(conv_start_n), .standby_n(standby_n), .skip_sleep(skip_sleep)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offset of the next start, relative to the previous start, from the requirements
  function automatic int exp_gap(int e, int p, int thr, int ws, int wl, bit skip);
    if (skip) return (p > e + 1) ? p : e + 1;
    for (int a = e + 1; a < e + p + wl + 4; a++) begin
      int len = a - e;
      int l = (len >= thr) ? wl : ws;
      if ((a - 1) + l + 2 >= p) return a + l + 1;
    end
    return -1;
  endfunction

  task automatic run_cfg(input int p, input int b, input int cbusy, input int ws,
                         input int wl, input int thr, input int pw, input int nstarts);
    bit exp_skip;
    int starts, prev_start, rise_t, fall_t, drop_t, bcnt, pulse_t, sleep_len, e_off;
    bit prev_st, prev_sb, slept;
    rst = 1'b1;
    busy = 1'b0;
    cfg_period = CW'(p); cfg_busy = CW'(cbusy); cfg_wake_short = CW'(ws);
    cfg_wake_long = CW'(wl); cfg_long_thresh = CW'(thr); cfg_pulse = PW'(pw);
    repeat (3) @(negedge clk);
    check(conv_start_n && standby_n, "R1 reset outputs", {conv_start_n, standby_n}, 3);
    exp_skip = (p < cbusy + ws + 2);
    rst = 1'b0;
    rise_t = cyc; prev_start = 0; starts = 0; drop_t = -100; fall_t = 0;
    bcnt = 0; pulse_t = 0; slept = 0; sleep_len = 0; e_off = 0;
    prev_st = 1'b1; prev_sb = 1'b1;
    @(negedge clk);
    check(conv_start_n && standby_n, "R1 after reset", {conv_start_n, standby_n}, 3);
    check(skip_sleep == exp_skip, "R9 skip flag", skip_sleep, exp_skip);
    while (starts < nstarts && !done) begin
      // converter model
      if (busy) begin
        bcnt--;
        if (bcnt == 0) begin busy = 1'b0; drop_t = cyc; end
      end
      if (!conv_start_n && prev_st) begin
        busy = 1'b1; bcnt = b;
      end
      if (!conv_start_n && !standby_n)
        check(0, "R8 start while in standby", 1, 0);
      if (!standby_n && prev_sb) begin
        fall_t = cyc; slept = 1;
        check(cyc == drop_t + 1, "R3 standby fall timing", cyc - drop_t, 1);
        check(!exp_skip, "R9 standby in skip mode", 1, 0);
      end
      if (standby_n && !prev_sb) begin
        rise_t = cyc; sleep_len = cyc - fall_t;
      end
      if (conv_start_n && !prev_st)
        check(cyc - pulse_t == ((pw == 0) ? 1 : pw), "R7 strobe width",
              cyc - pulse_t, (pw == 0) ? 1 : pw);
      if (!conv_start_n && prev_st) begin
        if (starts == 0) begin
          check(cyc - rise_t == wl + 1, "R2 initial wait", cyc - rise_t, wl + 1);
        end else begin
          int g = exp_gap(e_off, p, thr, ws, wl, exp_skip);
          check(cyc - prev_start == g, "R6 start spacing", cyc - prev_start, g);
          if (slept) begin
            int l = (sleep_len >= thr) ? wl : ws;
            check(cyc - rise_t == l + 1, "R4 R5 wake lead", cyc - rise_t, l + 1);
          end
        end
        starts++; prev_start = cyc; pulse_t = cyc; slept = 0;
      end
      if (!busy && drop_t == cyc) e_off = cyc + 1 - prev_start;
      prev_st = conv_start_n; prev_sb = standby_n;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) cyc <= cyc + 1;

  initial begin
    void'($urandom(32'd20240607));
    // directed corners
    run_cfg(200, 10, 11, 4, 30, 1000000, 0, 5);  // never long, one-cycle strobe (R7)
    run_cfg(120, 8, 9, 3, 25, 1, 2, 5);          // always long (R5)
    run_cfg(60, 10, 11, 5, 40, 20, 1, 5);        // tight period, late long wake (R6)
    run_cfg(6, 12, 13, 2, 9, 5, 3, 5);           // skip, busy longer than period (R9)
    run_cfg(18, 10, 11, 8, 20, 5, 1, 5);         // skip, period exact (R9)
    for (int i = 0; i < 20; i++) begin
      int ws = 1 + $urandom % 16;
      int wl = ws + 1 + $urandom % 40;
      int pw = $urandom % 5;
      int b  = ((pw == 0) ? 1 : pw) + 2 + $urandom % 20;
      int p  = b + 2 + $urandom % (wl + 150);
      int thr = 1 + $urandom % 150;
      run_cfg(p, b, b + 1, ws, wl, thr, pw, 6);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule